// File: doc/BRIEF.md
# Gain-Scaled QPSK Symbol Mapper

This block turns a serial stream of already-scrambled bits into packed complex QPSK samples. Each sample is two signed 16-bit parts. Every bit of a pair picks either the positive or the negative copy of one gain value. The gain comes from a 16-bit signed amplitude. With a single transmit port it is scaled by 1/√2 in Q15 fixed point. With several ports it is halved instead.

Software or an upstream sequencer starts a block with a load pulse. The pulse carries the amplitude, the port-count flag and the block length in bits. A control channel built from L resource units would use 72·L bits, which gives 36·L samples. Bits are then taken one per handshake. Samples leave through a valid/ready output stage, and the final sample of the block carries a last flag. A block with an odd length ends on a bit that has no partner. That bit is consumed and dropped, and an error pulse reports it.

Top module: `qpsk_gain_mapper`

## Requirements
- R1: After reset, `smp_valid`, `bit_ready`, `smp_last` and `odd_err` are all low.
- R2: With `cfg_multi_port` low, the gain is the 16-bit truncation of (amp × 23170) shifted arithmetically right by 15, which rounds toward minus infinity.
- R3: With `cfg_multi_port` high, the gain is amp / 2 truncated toward zero (for example, −3 gives −1 and −32768 gives −16384).
- R4: A bit of value 1 gives the part −gain, and a bit of value 0 gives +gain.
- R5: The first bit of each pair sets the in-phase part in `smp_data[15:0]`. The second bit sets the quadrature part in `smp_data[31:16]`.
- R6: A load accepted while idle starts a block of `cfg_len` bits. The block yields floor(`cfg_len`/2) samples, and `smp_last` is high only on the final one.
- R7: When `cfg_len` is odd, the final bit is accepted but produces no sample. `odd_err` is high for exactly one cycle, in the cycle after that bit is taken.
- R8: A `cfg_load` that arrives while bits remain or a sample is still undelivered is ignored. The gain and the remaining length of the current block are unchanged.
- R9: While `smp_valid` is high and `smp_ready` is low, `smp_valid`, `smp_data` and `smp_last` keep their values.
- R10: `bit_ready` is low whenever no block is in progress. A load with `cfg_len` = 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Start-of-block pulse |
| cfg_amp | input | 16 | Signed amplitude |
| cfg_multi_port | input | 1 | 1 = more than one transmit port |
| cfg_len | input | LEN_W | Block length in bits |
| bit_valid | input | 1 | Input bit present |
| bit_data | input | 1 | Scrambled input bit |
| bit_ready | output | 1 | Mapper takes the bit this cycle |
| smp_valid | output | 1 | Output sample present |
| smp_ready | input | 1 | Consumer takes the sample |
| smp_data | output | 32 | Packed sample: Q in [31:16], I in [15:0] |
| smp_last | output | 1 | Final sample of the block |
| odd_err | output | 1 | One-cycle pulse: trailing unpaired bit dropped |

## Verification
The checker assumes that the upstream source only pulses `cfg_load` as a request, and that the consumer may stall `smp_ready` at any point. It also assumes that `cfg_amp` and `cfg_multi_port` matter only in the cycle a load is accepted, so the properties tie each sample to the gain held for the block. The directed stimulus drives every input on the falling edge and sends bits only while a block is declared. It injects a second load in the middle of a block to exercise the ignore rule. It toggles `smp_ready` in a fixed pattern to produce holds.

// File: rtl/qpsk_map_pkg.sv
package qpsk_map_pkg;

  localparam int AMP_W    = 16;
  localparam int PROD_W   = 2 * AMP_W;
  localparam int SMP_W    = 2 * AMP_W;
  localparam int Q15_FRAC = 15;
  localparam logic signed [PROD_W-1:0] INV_SQRT2_Q15 = 32'sd23170;

  typedef logic signed [AMP_W-1:0] part_t;

  typedef struct packed {
    part_t q_part;
    part_t i_part;
  } smp_t;

  // amplitude scaled by 1/sqrt(2) in Q15, floor rounding
  function automatic part_t gain_single(input part_t amp);
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shf;
    prod = PROD_W'(amp) * INV_SQRT2_Q15;
    shf  = prod >>> Q15_FRAC;
    return shf[AMP_W-1:0];
  endfunction

  // amplitude halved, truncating toward zero
  function automatic part_t gain_multi(input part_t amp);
    logic signed [AMP_W:0] biased;
    logic signed [AMP_W:0] half;
    biased = $signed({amp[AMP_W-1], amp}) + $signed({{AMP_W{1'b0}}, amp[AMP_W-1]});
    half   = biased >>> 1;
    return half[AMP_W-1:0];
  endfunction

  function automatic part_t gain_calc(input part_t amp, input logic multi);
    return multi ? gain_multi(amp) : gain_single(amp);
  endfunction

  // bit 1 selects the negative level
  function automatic part_t level_of(input logic b, input part_t g);
    part_t neg;
    neg = -g;
    return b ? neg : g;
  endfunction

endpackage

// File: rtl/qmap_gain_unit.sv
module qmap_gain_unit
  import qpsk_map_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_acc,
  input  part_t amp,
  input  logic  multi,
  output part_t gain
);

  part_t gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gain_q <= '0;
    else if (load_acc) gain_q <= gain_calc(amp, multi);
  end

  assign gain = gain_q;

endmodule

// File: rtl/qmap_pair_ctrl.sv
module qmap_pair_ctrl #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_acc,
  input  logic [LEN_W-1:0] len,
  input  logic             bit_valid,
  input  logic             bit_data,
  input  logic             slot_free,
  output logic             bit_ready,
  output logic             busy,
  output logic             push,
  output logic             push_last,
  output logic             first_bit,
  output logic             odd_err
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  logic [LEN_W-1:0] rem_q;
  logic             half_q;
  logic             first_q;
  logic             odd_q;
  logic             fire;
  logic             tail_drop;

  assign busy      = (rem_q != '0);
  assign bit_ready = busy && (!half_q || slot_free);
  assign fire      = bit_valid && bit_ready;
  assign push      = fire && half_q;
  // last pair: nothing remains, or only a lone trailing bit remains
  assign push_last = push && ((rem_q == ONE) || (rem_q == TWO));
  assign tail_drop = fire && !half_q && (rem_q == ONE);
  assign first_bit = first_q;
  assign odd_err   = odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      half_q  <= 1'b0;
      first_q <= 1'b0;
      odd_q   <= 1'b0;
    end else begin
      odd_q <= tail_drop;
      if (load_acc) begin
        rem_q  <= len;
        half_q <= 1'b0;
      end else if (fire) begin
        rem_q <= rem_q - ONE;
        if (half_q) begin
          half_q <= 1'b0;
        end else if (!tail_drop) begin
          half_q  <= 1'b1;
          first_q <= bit_data;
        end
      end
    end
  end

endmodule

// File: rtl/qmap_out_stage.sv
module qmap_out_stage
  import qpsk_map_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_last,
  input  logic             i_bit,
  input  logic             q_bit,
  input  part_t            gain,
  input  logic             smp_ready,
  output logic             slot_free,
  output logic             smp_valid,
  output logic [SMP_W-1:0] smp_data,
  output logic             smp_last
);

  localparam int N_LANE = 2;

  logic [N_LANE-1:0] lane_bit;
  part_t             lane_lvl [N_LANE];
  smp_t              nxt;
  smp_t              data_q;
  logic              valid_q;
  logic              last_q;

  assign lane_bit = {q_bit, i_bit};

  for (genvar g = 0; g < N_LANE; g++) begin : gen_lane
    assign lane_lvl[g] = level_of(lane_bit[g], gain);
  end

  assign nxt.i_part = lane_lvl[0];
  assign nxt.q_part = lane_lvl[1];
  assign slot_free  = !valid_q || smp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else if (push) begin
      valid_q <= 1'b1;
      data_q  <= nxt;
      last_q  <= push_last;
    end else if (smp_ready) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end
  end

  assign smp_valid = valid_q;
  assign smp_data  = data_q;
  assign smp_last  = last_q;

endmodule

// File: rtl/qpsk_gain_mapper.sv
module qpsk_gain_mapper
  import qpsk_map_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [15:0]      cfg_amp,
  input  logic             cfg_multi_port,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  output logic             smp_valid,
  input  logic             smp_ready,
  output logic [31:0]      smp_data,
  output logic             smp_last,
  output logic             odd_err
);

  logic  busy_w;
  logic  load_acc_w;
  logic  push_w;
  logic  push_last_w;
  logic  first_bit_w;
  logic  slot_free_w;
  part_t gain_w;

  // a block is in progress until every bit is taken and the last sample delivered
  assign load_acc_w = cfg_load && !busy_w && !smp_valid;

  qmap_gain_unit u_gain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_acc (load_acc_w),
    .amp      ($signed(cfg_amp)),
    .multi    (cfg_multi_port),
    .gain     (gain_w)
  );

  qmap_pair_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_acc  (load_acc_w),
    .len       (cfg_len),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .slot_free (slot_free_w),
    .bit_ready (bit_ready),
    .busy      (busy_w),
    .push      (push_w),
    .push_last (push_last_w),
    .first_bit (first_bit_w),
    .odd_err   (odd_err)
  );

  qmap_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_w),
    .push_last (push_last_w),
    .i_bit     (first_bit_w),
    .q_bit     (bit_data),
    .gain      (gain_w),
    .smp_ready (smp_ready),
    .slot_free (slot_free_w),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_last  (smp_last)
  );

endmodule

// File: rtl/qpsk_gain_mapper_chk.sv
module qpsk_gain_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_load,
  input logic        bit_valid,
  input logic        bit_ready,
  input logic        smp_valid,
  input logic        smp_ready,
  input logic [31:0] smp_data,
  input logic        smp_last,
  input logic        odd_err,
  input logic        busy,
  input logic [15:0] gain
);

  logic signed [15:0] pos_g;
  logic signed [15:0] neg_g;
  logic signed [15:0] i_p;
  logic signed [15:0] q_p;

  assign pos_g = $signed(gain);
  assign neg_g = -pos_g;
  assign i_p   = $signed(smp_data[15:0]);
  assign q_p   = $signed(smp_data[31:16]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(smp_last)));

  assert_level_i_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (i_p == pos_g || i_p == neg_g));

  assert_level_q_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (q_p == pos_g || q_p == neg_g));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bit_ready);

  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && (busy || smp_valid)) |=> $stable(gain));

  assert_odd_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    odd_err |-> ($past(bit_valid && bit_ready) && !busy));

  assert_odd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    odd_err |=> !odd_err);

endmodule

bind qpsk_gain_mapper qpsk_gain_mapper_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_load  (cfg_load),
  .bit_valid (bit_valid),
  .bit_ready (bit_ready),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .smp_data  (smp_data),
  .smp_last  (smp_last),
  .odd_err   (odd_err),
  .busy      (busy_w),
  .gain      (gain_w)
);

// File: tb/qpsk_gain_mapper_tb_top.sv
module qpsk_gain_mapper_tb_top;

  localparam int LEN_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_load = 1'b0;
  logic [15:0]      cfg_amp = '0;
  logic             cfg_multi_port = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic             bit_valid = 1'b0;
  logic             bit_data = 1'b0;
  logic             bit_ready;
  logic             smp_valid;
  logic             smp_ready = 1'b1;
  logic [31:0]      smp_data;
  logic             smp_last;
  logic             odd_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  qpsk_gain_mapper #(.LEN_W(LEN_W)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_load       (cfg_load),
    .cfg_amp        (cfg_amp),
    .cfg_multi_port (cfg_multi_port),
    .cfg_len        (cfg_len),
    .bit_valid      (bit_valid),
    .bit_data       (bit_data),
    .bit_ready      (bit_ready),
    .smp_valid      (smp_valid),
    .smp_ready      (smp_ready),
    .smp_data       (smp_data),
    .smp_last       (smp_last),
    .odd_err        (odd_err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // gain restated from R2 / R3 with integer division
  function automatic int exp_gain(input int amp, input bit multi);
    int p;
    if (multi) return amp / 2;
    p = amp * 23170;
    if (p >= 0) return p / 32768;
    return -((-p + 32767) / 32768);
  endfunction

  function automatic bit pat_bit(input int seed, input int k);
    return bit'(((k * 5 + seed) >> 1) & 1);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 smp_valid", int'(smp_valid), 0);
    check("R1 bit_ready", int'(bit_ready), 0);
    check("R1 smp_last", int'(smp_last), 0);
    check("R1 odd_err", int'(odd_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_block(input int amp, input bit multi, input int len, input int seed,
                           input bit stall, input bit inject, input string tag);
    int  k = 0;
    int  j = 0;
    int  odd_cnt = 0;
    int  tail = 0;
    int  cyc = 0;
    int  g;
    bit  injected = 0;
    bit  hold = 0;
    logic [31:0] held;
    int  nsym;
    g    = exp_gain(amp, multi);
    nsym = len / 2;
    @(negedge clk);
    cfg_load = 1'b1; cfg_amp = 16'(amp); cfg_multi_port = multi; cfg_len = LEN_W'(len);
    @(negedge clk);
    cfg_load = 1'b0;
    while ((k < len || j < nsym || tail < 3) && cyc < 4000) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (k >= len && j >= nsym) tail++;
      smp_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      bit_valid = (k < len);
      bit_data  = (k < len) ? pat_bit(seed, k) : 1'b0;
      if (inject && k == 2 && !injected) begin
        injected = 1;
        cfg_load = 1'b1; cfg_amp = 16'd1234; cfg_multi_port = !multi; cfg_len = LEN_W'(3);
      end else begin
        cfg_load = 1'b0;
      end
      #1;
      if (odd_err) odd_cnt++;
      if (hold) begin
        // R9: held sample unchanged
        check("R9 held valid", int'(smp_valid), 1);
        check("R9 held data", int'(smp_data), int'(held));
      end
      hold = smp_valid && !smp_ready;
      held = smp_data;
      if (smp_valid && smp_ready) begin
        int ei;
        int eq;
        ei = pat_bit(seed, 2 * j)     ? -g : g;
        eq = pat_bit(seed, 2 * j + 1) ? -g : g;
        check({tag, " R4 R5 I part"}, int'($signed(smp_data[15:0])), ei);
        check({tag, " R4 R5 Q part"}, int'($signed(smp_data[31:16])), eq);
        check({tag, " R6 last flag"}, int'(smp_last), (j == nsym - 1) ? 1 : 0);
        j++;
      end
      if (bit_valid && bit_ready) k++;
    end
    bit_valid = 1'b0;
    cfg_load  = 1'b0;
    smp_ready = 1'b1;
    check({tag, " R6 sample count"}, j, nsym);
    check({tag, " R6 bits taken"}, k, len);
    check({tag, " R7 odd pulses"}, odd_cnt, len % 2);
    check({tag, " R10 idle bit_ready"}, int'(bit_ready), 0);
    if (inject) check({tag, " R8 load ignored"}, int'(injected), 1);
  endtask

  task automatic t_zero_len();
    @(negedge clk);
    cfg_load = 1'b1; cfg_len = '0; cfg_amp = 16'd500;
    @(negedge clk);
    cfg_load  = 1'b0;
    bit_valid = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R10 zero length bit_ready", int'(bit_ready), 0);
      check("R10 zero length smp_valid", int'(smp_valid), 0);
    end
    bit_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    run_block(10000, 1'b0, 16, 0, 1'b0, 1'b0, "R2 single port");
    run_block(12345, 1'b1, 12, 3, 1'b1, 1'b0, "R3 multi port stall");
    run_block(-3, 1'b1, 5, 1, 1'b0, 1'b0, "R3 R7 odd negative");
    run_block(-32768, 1'b0, 8, 2, 1'b0, 1'b0, "R2 most negative");
    run_block(32767, 1'b0, 9, 6, 1'b1, 1'b0, "R2 R7 odd stall");
    run_block(2000, 1'b1, 10, 4, 1'b1, 1'b1, "R8 load mid block");
    run_block(1000, 1'b0, 72, 5, 1'b0, 1'b0, "R6 one unit");
    run_block(-32768, 1'b1, 4, 7, 1'b0, 1'b0, "R3 half of most negative");
    t_zero_len();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule